// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block moves a small embedded processor core between its running, idle and power-down states. Software raises a one-cycle request strobe for idle or power-down. The block then turns off the core clock through a gate enable, and in power-down it also drops the oscillator enable. It watches three active-low wake pins: two external interrupt lines and the serial receive line. A falling edge on a pin whose enables are set brings the core back.

Idle keeps the oscillator running, so a wake returns the core to the running state at once. Power-down stops the oscillator. A wake from power-down therefore passes through a settle phase: the oscillator enable comes back, the core clock stays gated for a programmable number of cycles, and the interrupt line that caused the wake is held low for that whole phase. When the phase ends, the clock gate opens and the held line is released. The block also sets the levels of the bus-control pins and the port modes for each state. Hardware reset, taken asynchronously, always returns the block to the running state.

The wake detectors run on `clk`, a slow reference clock that never stops. All pin inputs pass through two synchronizer flops before any decision is made.

States: `ST_RUN` (core clocked), `ST_IDLE` (core clock gated, oscillator on), `ST_PDOWN` (oscillator off), `ST_SETTLE` (oscillator restarting, core clock still gated).

Transitions:
- `RUN→PDOWN` on a power-down request. This wins when both requests are raised in the same cycle.
- `RUN→IDLE` on an idle request.
- Either of the two entries above is cancelled when a qualified wake edge arrives in the same cycle.
- `IDLE→RUN` on a qualified wake edge.
- `PDOWN→SETTLE` on a qualified wake edge.
- `SETTLE→RUN` when the settle timer expires.
- Any state goes to `RUN` on reset.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset, `osc_en`=1 and `cpu_clk_en`=1, and both interrupt outputs are high while the pins are high.
- R2: An idle request in the running state gives, one cycle later: `cpu_clk_en`=0, `osc_en`=1, `ale`=1, `psen_n`=1, `p0_float`=`ext_prog`, and `p2_addr_sel`=`ext_prog`. Here `p2_addr_sel`=1 means port 2 carries address.
- R3: A power-down request gives, one cycle later: `osc_en`=0, `cpu_clk_en`=0, `ale`=0, `psen_n`=0, `p0_float`=`ext_prog` and `p2_addr_sel`=0. When both requests are raised together, power-down wins.
- R4: In idle, a qualified falling edge sets `cpu_clk_en` back to 1 on the third rising clock edge after the pin falls.
- R5: In power-down, a qualified falling edge enters the settle phase on the third rising edge after the pin falls. In that phase `osc_en`=1, `cpu_clk_en`=0, the power-down pin levels stay in place, and the wake source's interrupt output is held low.
- R6: The settle phase lasts exactly `SETTLE_CYCLES` clock cycles. After it, `cpu_clk_en`=1 and the held interrupt output is released.
- R7: A falling edge on `int1_pin_n` wakes the block only when `en_int1`=1. Otherwise the block stays in its low-power state.
- R8: A falling edge on `rx_pin` wakes the block only when both `en_int1` and `en_rx` are 1. An RX wake is reported on `int1_n_out`.
- R9: A falling edge on `int0_pin_n` wakes the block only when `en_int0`=1.
- R10: A qualified wake edge in the same cycle as a mode request cancels the entry: `osc_en` and `cpu_clk_en` stay 1.
- R11: Asserting `rst_n` low in any state returns at once to `osc_en`=1 and `cpu_clk_en`=1.
- R12: In the running state, `ale`=`core_ale`, `psen_n`=`core_psen_n`, `p0_float`=0 and `p2_addr_sel`=`ext_prog`. Each interrupt output follows its own pin two rising edges after the pin changes; RX has no effect on `int1_n_out` outside the settle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_idle | input | 1 | One-cycle idle request from software |
| req_pdown | input | 1 | One-cycle power-down request from software |
| en_int0 | input | 1 | Wake enable for interrupt line 0 |
| en_int1 | input | 1 | Wake enable for interrupt line 1 (also needed for RX) |
| en_rx | input | 1 | Extra wake enable for the receive line |
| ext_prog | input | 1 | 1 when program memory is external |
| core_ale | input | 1 | Address latch enable from the core while running |
| core_psen_n | input | 1 | Program store enable from the core while running |
| int0_pin_n | input | 1 | Raw interrupt pin 0, active low |
| int1_pin_n | input | 1 | Raw interrupt pin 1, active low |
| rx_pin | input | 1 | Raw serial receive line, idle high |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Core clock gate enable |
| int0_n_out | output | 1 | Interrupt 0 to the core, stretched during settle |
| int1_n_out | output | 1 | Interrupt 1 to the core, stretched during settle |
| ale | output | 1 | Address latch enable pin level |
| psen_n | output | 1 | Program store enable pin level |
| p0_float | output | 1 | 1 puts port 0 in high impedance |
| p2_addr_sel | output | 1 | 1 puts address on port 2, 0 puts data |

## Verification
Mode requests take effect on the next rising edge. The bench raises a strobe just after a falling edge and samples one falling edge later. A wake edge crosses two synchronizer flops and one edge register, so the state changes on the third rising edge after the pin falls. The bench moves pins only at falling edges and samples the result exactly three falling edges later, and also checks one edge before that to confirm nothing happens early. The settle window is checked at its last cycle and at the cycle after it, which pins its length to `SETTLE_CYCLES`. Pass-through interrupt levels are sampled at one and at two edges after the pin moves.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PDOWN  = 2'd2,
        ST_SETTLE = 2'd3
    } lpw_state_e;

    localparam int unsigned PIN_INT0 = 0;
    localparam int unsigned PIN_INT1 = 1;
    localparam int unsigned PIN_RX   = 2;
    localparam int unsigned NUM_PINS = 3;

    typedef struct packed {
        logic line1;
        logic line0;
    } stretch_t;

endpackage

// File: rtl/lpw_edge_sync.sv
module lpw_edge_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_raw[g]};
                prev_q  <= chain_q[LAST];
            end
        end

        assign level[g] = chain_q[LAST];
        assign fall[g]  = prev_q & ~chain_q[LAST];
    end

endmodule

// File: rtl/lpw_wake_qual.sv
module lpw_wake_qual
    import lpw_pkg::*;
(
    input  logic [NUM_PINS-1:0] fall,
    input  logic                en_int0,
    input  logic                en_int1,
    input  logic                en_rx,
    output logic                wake_line0,
    output logic                wake_line1,
    output logic                wake_any
);
    logic rx_ok;

    always_comb begin
        rx_ok      = fall[PIN_RX] & en_int1 & en_rx;
        wake_line0 = fall[PIN_INT0] & en_int0;
        wake_line1 = (fall[PIN_INT1] & en_int1) | rx_ok;
        wake_any   = wake_line0 | wake_line1;
    end

endmodule

// File: rtl/lpw_settle_timer.sv
module lpw_settle_timer #(
    parameter int unsigned CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic done
);
    localparam int unsigned CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (active && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = active && (cnt_q == LIMIT);

endmodule

// File: rtl/lpw_pin_mux.sv
module lpw_pin_mux
    import lpw_pkg::*;
(
    input  lpw_state_e state,
    input  logic       ext_prog,
    input  logic       core_ale,
    input  logic       core_psen_n,
    output logic       ale,
    output logic       psen_n,
    output logic       p0_float,
    output logic       p2_addr_sel
);
    always_comb begin
        unique case (state)
            ST_RUN: begin
                ale         = core_ale;
                psen_n      = core_psen_n;
                p0_float    = 1'b0;
                p2_addr_sel = ext_prog;
            end
            ST_IDLE: begin
                ale         = 1'b1;
                psen_n      = 1'b1;
                p0_float    = ext_prog;
                p2_addr_sel = ext_prog;
            end
            ST_PDOWN, ST_SETTLE: begin
                ale         = 1'b0;
                psen_n      = 1'b0;
                p0_float    = ext_prog;
                p2_addr_sel = 1'b0;
            end
            default: begin
                ale         = core_ale;
                psen_n      = core_psen_n;
                p0_float    = 1'b0;
                p2_addr_sel = ext_prog;
            end
        endcase
    end

endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 1024,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_idle,
    input  logic req_pdown,
    input  logic en_int0,
    input  logic en_int1,
    input  logic en_rx,
    input  logic ext_prog,
    input  logic core_ale,
    input  logic core_psen_n,
    input  logic int0_pin_n,
    input  logic int1_pin_n,
    input  logic rx_pin,
    output logic osc_en,
    output logic cpu_clk_en,
    output logic int0_n_out,
    output logic int1_n_out,
    output logic ale,
    output logic psen_n,
    output logic p0_float,
    output logic p2_addr_sel
);
    lpw_state_e          state_q, state_d;
    stretch_t            hold_q, hold_d;
    logic [NUM_PINS-1:0] pin_raw, pin_lvl, pin_fall;
    logic                wake_line0, wake_line1, wake_any;
    logic                tmr_start, tmr_done;

    always_comb begin
        pin_raw           = '1;
        pin_raw[PIN_INT0] = int0_pin_n;
        pin_raw[PIN_INT1] = int1_pin_n;
        pin_raw[PIN_RX]   = rx_pin;
    end

    lpw_edge_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_raw),
        .level   (pin_lvl),
        .fall    (pin_fall)
    );

    lpw_wake_qual u_qual (
        .fall       (pin_fall),
        .en_int0    (en_int0),
        .en_int1    (en_int1),
        .en_rx      (en_rx),
        .wake_line0 (wake_line0),
        .wake_line1 (wake_line1),
        .wake_any   (wake_any)
    );

    lpw_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .active (state_q == ST_SETTLE),
        .done   (tmr_done)
    );

    // next state and held interrupt source
    always_comb begin
        state_d   = state_q;
        hold_d    = hold_q;
        tmr_start = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (!wake_any) begin
                    if (req_pdown)     state_d = ST_PDOWN;
                    else if (req_idle) state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (wake_any) state_d = ST_RUN;
            end
            ST_PDOWN: begin
                if (wake_any) begin
                    state_d      = ST_SETTLE;
                    tmr_start    = 1'b1;
                    hold_d.line0 = wake_line0;
                    hold_d.line1 = wake_line1;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    state_d = ST_RUN;
                    hold_d  = '0;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:    begin osc_en = 1'b1; cpu_clk_en = 1'b1; end
            ST_IDLE:   begin osc_en = 1'b1; cpu_clk_en = 1'b0; end
            ST_PDOWN:  begin osc_en = 1'b0; cpu_clk_en = 1'b0; end
            ST_SETTLE: begin osc_en = 1'b1; cpu_clk_en = 1'b0; end
            default:   begin osc_en = 1'b1; cpu_clk_en = 1'b1; end
        endcase
        int0_n_out = pin_lvl[PIN_INT0] & ~hold_q.line0;
        int1_n_out = pin_lvl[PIN_INT1] & ~hold_q.line1;
    end

    lpw_pin_mux u_pins (
        .state       (state_q),
        .ext_prog    (ext_prog),
        .core_ale    (core_ale),
        .core_psen_n (core_psen_n),
        .ale         (ale),
        .psen_n      (psen_n),
        .p0_float    (p0_float),
        .p2_addr_sel (p2_addr_sel)
    );

endmodule

// File: rtl/lpw_checker.sv
module lpw_checker
    import lpw_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input lpw_state_e state,
    input logic       req_idle,
    input logic       req_pdown,
    input logic       wake_any,
    input logic       osc_en,
    input logic       cpu_clk_en,
    input logic       ale,
    input logic       psen_n,
    input logic       int0_n_out,
    input logic       int1_n_out
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 2);
    logic [CW-1:0] settle_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     settle_len_q <= '0;
        else if (osc_en && !cpu_clk_en && state == ST_SETTLE)
                                        settle_len_q <= settle_len_q + 1'b1;
        else                            settle_len_q <= '0;
    end

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && req_idle && !req_pdown && !wake_any)
        |=> (!cpu_clk_en && osc_en && ale && psen_n)); // R2

    AST_PDOWN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && req_pdown && !wake_any)
        |=> (!osc_en && !cpu_clk_en && !ale && !psen_n)); // R3

    AST_OSC_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> !cpu_clk_en); // R5

    AST_SETTLE_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (!int0_n_out || !int1_n_out)); // R5

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        settle_len_q <= CW'(SETTLE_CYCLES)); // R6

    AST_CLK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> osc_en); // R6

    AST_CANCEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && (req_pdown || req_idle) && wake_any)
        |=> (cpu_clk_en && osc_en)); // R10

endmodule

bind lpm_wake_ctrl lpw_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .req_idle   (req_idle),
    .req_pdown  (req_pdown),
    .wake_any   (wake_any),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .ale        (ale),
    .psen_n     (psen_n),
    .int0_n_out (int0_n_out),
    .int1_n_out (int1_n_out)
);

// File: tb/sim_lpm_wake_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_wake_ctrl;
    localparam int unsigned SETTLE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_idle = 0, req_pdown = 0, en_int0 = 0, en_int1 = 0, en_rx = 0;
    logic ext_prog = 0, core_ale = 0, core_psen_n = 1;
    logic int0_pin_n = 1, int1_pin_n = 1, rx_pin = 1;
    logic osc_en, cpu_clk_en, int0_n_out, int1_n_out, ale, psen_n, p0_float, p2_addr_sel;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    lpm_wake_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
        end
    endtask

    task automatic nx(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit wake_expect(input int src, input bit e0, input bit e1, input bit erx);
        case (src)
            0: return e0;
            1: return e1;
            default: return e1 && erx;
        endcase
    endfunction

    task automatic drop_pin(input int src);
        case (src)
            0: int0_pin_n = 1'b0;
            1: int1_pin_n = 1'b0;
            default: rx_pin = 1'b0;
        endcase
    endtask

    task automatic quiet_reset();
        int0_pin_n = 1; int1_pin_n = 1; rx_pin = 1;
        req_idle = 0; req_pdown = 0;
        rst_n = 0;
        nx(2);
        rst_n = 1;
        nx(4);
    endtask

    task automatic enter(input bit pdown);
        if (pdown) req_pdown = 1; else req_idle = 1;
        nx(1);
        req_pdown = 0; req_idle = 0;
    endtask

    task automatic trial(input bit pdown, input int src, input bit e0, input bit e1, input bit erx);
        bit exp_w;
        exp_w = wake_expect(src, e0, e1, erx);
        en_int0 = e0; en_int1 = e1; en_rx = erx;
        enter(pdown);
        if (pdown) begin
            chk(!osc_en && !cpu_clk_en && !ale && !psen_n && p2_addr_sel == 0 && p0_float == ext_prog,
                "R3 pdown pins", {osc_en, cpu_clk_en, ale, psen_n}, 0);
        end else begin
            chk(osc_en && !cpu_clk_en && ale && psen_n && p0_float == ext_prog && p2_addr_sel == ext_prog,
                "R2 idle pins", {osc_en, cpu_clk_en, ale, psen_n}, 4'b1011);
        end
        drop_pin(src);
        nx(2);
        chk(!cpu_clk_en, "R4/R5 no early wake", cpu_clk_en, 0);
        nx(1);
        if (!exp_w) begin
            chk(!cpu_clk_en && osc_en == !pdown, "R7/R8/R9 disabled edge ignored", cpu_clk_en, 0);
        end else if (!pdown) begin
            chk(cpu_clk_en && osc_en, "R4 idle wake", cpu_clk_en, 1);
        end else begin
            chk(osc_en && !cpu_clk_en && !ale && !psen_n, "R5 settle phase", {osc_en, cpu_clk_en}, 2);
            chk((src == 0) ? (int0_n_out == 0) : (int1_n_out == 0), "R5/R8 stretched line",
                (src == 0) ? int0_n_out : int1_n_out, 0);
            int0_pin_n = 1; int1_pin_n = 1; rx_pin = 1;
            nx(SETTLE - 1);
            chk(!cpu_clk_en, "R6 settle last cycle", cpu_clk_en, 0);
            chk(int0_n_out == 0 || int1_n_out == 0, "R6 still held", {int0_n_out, int1_n_out}, 1);
            nx(1);
            chk(cpu_clk_en && int0_n_out && int1_n_out, "R6 settle end", {cpu_clk_en, int0_n_out, int1_n_out}, 7);
        end
        quiet_reset();
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        nx(2);
        chk(osc_en && cpu_clk_en, "R11 reset held", {osc_en, cpu_clk_en}, 3);
        rst_n = 1;
        nx(3);
        chk(osc_en && cpu_clk_en && int0_n_out && int1_n_out, "R1 reset state",
            {osc_en, cpu_clk_en, int0_n_out, int1_n_out}, 15);

        // R12 running pass-through
        ext_prog = 1; core_ale = 1; core_psen_n = 0;
        nx(1);
        chk(ale == 1 && psen_n == 0 && p0_float == 0 && p2_addr_sel == 1, "R12 run pins",
            {ale, psen_n, p0_float, p2_addr_sel}, 4'b1001);
        int0_pin_n = 0;
        nx(1);
        chk(int0_n_out == 1, "R12 int0 not yet", int0_n_out, 1);
        nx(1);
        chk(int0_n_out == 0, "R12 int0 follows", int0_n_out, 0);
        int0_pin_n = 1; rx_pin = 0;
        nx(3);
        chk(int1_n_out == 1, "R12 rx not on int1", int1_n_out, 1);
        rx_pin = 1;
        nx(3);

        // R3 priority when both requests
        req_idle = 1; req_pdown = 1;
        nx(1);
        req_idle = 0; req_pdown = 0;
        chk(!osc_en, "R3 pdown priority", osc_en, 0);
        rst_n = 0;
        nx(1);
        chk(osc_en && cpu_clk_en, "R11 reset exits pdown", {osc_en, cpu_clk_en}, 3);
        rst_n = 1;
        nx(3);

        // R10 cancel on same-cycle wake
        en_int0 = 1;
        int0_pin_n = 0;
        nx(2);
        req_pdown = 1;
        nx(1);
        req_pdown = 0;
        chk(osc_en && cpu_clk_en, "R10 cancel entry", {osc_en, cpu_clk_en}, 3);
        quiet_reset();

        // directed corners
        trial(1, 2, 1, 0, 1);   // R8 rx without int1 enable
        trial(1, 2, 0, 1, 1);   // R8 rx wake on int1 line
        trial(0, 1, 1, 0, 1);   // R7 int1 disabled
        trial(1, 0, 0, 1, 1);   // R9 int0 disabled
        trial(1, 0, 1, 0, 0);   // R9 int0 wake

        // constrained random
        for (int k = 0; k < 40; k++) begin
            ext_prog = 1'($urandom_range(0, 1));
            trial(1'($urandom_range(0, 1)), int'($urandom_range(0, 2)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule